// File: doc/BRIEF.md
# Warm Start Power-Up Sequencer

This block takes a system out of its low-power user-off state and into running operation. A turn-on event is accepted only while the block is in user-off. The block then spends a fixed initialization window, counted in ticks of a slow 32 kHz enable, during which bias, strap sampling and supply qualification happen elsewhere. If the supply is qualified when the window closes, the converters are brought up one per time slot in ascending index order, which spreads the inrush current. If it is not qualified, the block falls back to user-off.

Converters that the keep-on flags held running through user-off are never switched off. Each converter still gets a single-cycle load-default strobe in its own slot so that its default setting is reapplied. For the whole sequence the system reset is held low and the processor reset stays high. A separate reset timer starts at entry. Once that timer has expired and the last slot has ended, the block moves to the watchdog state. There it releases the system reset and sets a sticky warm-start interrupt that the host clears. The processor clock output keeps the setting captured at entry while the sequence runs.

Top module: `warm_start_seq`

## Requirements
- R1: A turn-on pulse starts the sequence only when the block is in user-off. A turn-on during the sequence or in the watchdog state changes no output.
- R2: The initialization window lasts INIT_TICKS tick-qualified clock edges after entry, and no converter enable changes during it. Only edges where tick is 1 advance any window, slot or timer.
- R3: If supply_ok is 0 at the end of the initialization window, the block returns to user-off with no converter enabled beyond the live keep_on flags, and a later turn-on starts a complete new sequence.
- R4: Converter k (k = 0 at bit 0 up to NUM_CONV-1) is enabled on the edge that closes tick number INIT_TICKS + k*SLOT_TICKS after entry. Converters are enabled in ascending index order, and each slot lasts SLOT_TICKS ticks.
- R5: In user-off, conv_en equals keep_on. At entry keep_on is captured, and a captured converter stays enabled for the whole sequence whatever keep_on does later. No enable falls anywhere outside user-off.
- R6: load_default bit k is a one-cycle pulse at the start of slot k, given for every converter, including converters kept on. At most one load_default bit is set in any cycle.
- R7: sys_rst_n is 0 from reset until the watchdog state. proc_rst_n is 1 at all times.
- R8: clk_out_en follows clk_cfg in user-off and in the watchdog state. During the sequence it holds the value clk_cfg had on the entry edge.
- R9: The reset timer counts RST_TICKS ticks from entry. The block enters the watchdog state on the first edge at which the timer has expired and the last slot has ended, and sys_rst_n goes to 1 on that edge.
- R10: warm_irq is set on the edge that enters the watchdog state and stays set until an irq_clear pulse, which clears it on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 32 kHz enable, one clock wide |
| turn_on | input | 1 | Turn-on event pulse |
| keep_on | input | NUM_CONV | Per-converter keep-on-in-user-off flags |
| supply_ok | input | 1 | Main supply qualified |
| clk_cfg | input | 1 | Processor clock output enable setting |
| irq_clear | input | 1 | Host clear of the warm-start interrupt |
| conv_en | output | NUM_CONV | Per-converter enables |
| load_default | output | NUM_CONV | Load-default-setting strobes |
| sys_rst_n | output | 1 | System reset, active low |
| proc_rst_n | output | 1 | Processor reset, active low |
| clk_out_en | output | 1 | Processor clock output enable |
| warm_irq | output | 1 | Sticky warm-start interrupt |

## Verification
The embedded assertions check several properties on every cycle: entry only comes from user-off, enables stay frozen during initialization and never fall outside user-off, the load strobes are single and one-hot, the clock enable is frozen during the sequence, the system reset rises only after the reset timer has expired, and the interrupt is present at that rise. The exact cycle of each slot edge, the ascending order, the fall-back on a failed supply and the later restart, and the fact that turn-on pulses outside user-off have no effect can only be shown by the bench's scenarios. In those scenarios a scoreboard compares every output change against times derived from the tick rate.

// File: rtl/ws_pkg.sv
package ws_pkg;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_INIT = 3'd1,
    ST_SEQ  = 3'd2,
    ST_HOLD = 3'd3,
    ST_WDOG = 3'd4
  } ws_state_e;

  // Length in ticks of the window currently being counted.
  function automatic int phase_limit(input bit in_init, input int init_t, input int slot_t);
    return in_init ? init_t : slot_t;
  endfunction

  // Tick number (from entry) at which slot k opens.
  function automatic int slot_open_tick(input int init_t, input int slot_t, input int k);
    return init_t + k * slot_t;
  endfunction

endpackage

// File: rtl/ws_sat_timer.sv
module ws_sat_timer #(
  parameter int LIMIT = 1024,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            cnt <= '0;
    else if (clear)                        cnt <= '0;
    else if (tick && cnt != CW'(LIMIT))    cnt <= cnt + CW'(1);
  end

  assign expired = (cnt == CW'(LIMIT));

  assert_timer_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT));
  assert_timer_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !clear) |=> expired);
endmodule

// File: rtl/ws_conv_bank.sv
module ws_conv_bank #(
  parameter int NUM_CONV = 5,
  parameter int IDX_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                latch,
  input  logic [NUM_CONV-1:0] keep_in,
  input  logic                live_off,
  input  logic                step,
  input  logic [IDX_W-1:0]    step_idx,
  output logic [NUM_CONV-1:0] en,
  output logic [NUM_CONV-1:0] load
);
  for (genvar i = 0; i < NUM_CONV; i++) begin : g_conv
    logic kept_q, on_q, ld_q;
    logic hit;
    assign hit = step && (step_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        kept_q <= 1'b0;
        on_q   <= 1'b0;
        ld_q   <= 1'b0;
      end else begin
        if (latch) kept_q <= keep_in[i];
        if (live_off)  on_q <= 1'b0;
        else if (hit)  on_q <= 1'b1;
        ld_q <= hit;
      end
    end

    assign en[i]   = live_off ? keep_in[i] : (kept_q | on_q);
    assign load[i] = ld_q;

    assert_load_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load[i] |=> !load[i]);
  end

  assert_load_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load));
  assert_en_no_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!live_off && !$past(live_off)) |-> ((en & $past(en)) == $past(en)));
endmodule

// File: rtl/ws_sticky_flag.sv
module ws_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
  assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/warm_start_seq.sv
module warm_start_seq
  import ws_pkg::*;
#(
  parameter int NUM_CONV   = 5,
  parameter int INIT_TICKS = 263,
  parameter int SLOT_TICKS = 16,
  parameter int RST_TICKS  = 1024
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                turn_on,
  input  logic [NUM_CONV-1:0] keep_on,
  input  logic                supply_ok,
  input  logic                clk_cfg,
  input  logic                irq_clear,
  output logic [NUM_CONV-1:0] conv_en,
  output logic [NUM_CONV-1:0] load_default,
  output logic                sys_rst_n,
  output logic                proc_rst_n,
  output logic                clk_out_en,
  output logic                warm_irq
);
  localparam int SW   = (NUM_CONV > 1) ? $clog2(NUM_CONV) : 1;
  localparam int PMAX = (INIT_TICKS > SLOT_TICKS) ? INIT_TICKS : SLOT_TICKS;
  localparam int PW   = $clog2(PMAX + 1);

  ws_state_e      state;
  logic [PW-1:0]  phase;
  logic [SW-1:0]  slot;
  logic           clk_hold;
  logic           rst_expired;

  // Named internal events
  logic phase_end, last_slot, in_warm;
  logic ev_enter, ev_init_end, ev_supply_bad, ev_slot_end, ev_seq_done, ev_to_wdog;
  logic step;
  logic [SW-1:0] step_idx;

  assign phase_end     = tick && (phase == PW'(phase_limit(state == ST_INIT, INIT_TICKS, SLOT_TICKS) - 1));
  assign last_slot     = (slot == SW'(NUM_CONV - 1));
  assign in_warm       = (state == ST_INIT) || (state == ST_SEQ) || (state == ST_HOLD);
  assign ev_enter      = (state == ST_OFF) && turn_on;
  assign ev_init_end   = (state == ST_INIT) && phase_end;
  assign ev_supply_bad = ev_init_end && !supply_ok;
  assign ev_slot_end   = (state == ST_SEQ) && phase_end;
  assign ev_seq_done   = ev_slot_end && last_slot;
  assign ev_to_wdog    = (state == ST_HOLD) && rst_expired;
  assign step          = (ev_init_end && supply_ok) || (ev_slot_end && !last_slot);
  assign step_idx      = ev_init_end ? '0 : slot + SW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_OFF;
      phase    <= '0;
      slot     <= '0;
      clk_hold <= 1'b0;
    end else begin
      case (state)
        ST_OFF: begin
          if (ev_enter) begin
            state    <= ST_INIT;
            phase    <= '0;
            clk_hold <= clk_cfg;
          end
        end
        ST_INIT: begin
          if (ev_init_end) begin
            phase <= '0;
            slot  <= '0;
            state <= supply_ok ? ST_SEQ : ST_OFF;
          end else if (tick) begin
            phase <= phase + PW'(1);
          end
        end
        ST_SEQ: begin
          if (ev_slot_end) begin
            phase <= '0;
            if (last_slot) state <= ST_HOLD;
            else           slot  <= slot + SW'(1);
          end else if (tick) begin
            phase <= phase + PW'(1);
          end
        end
        ST_HOLD: begin
          if (ev_to_wdog) state <= ST_WDOG;
        end
        ST_WDOG: state <= ST_WDOG;
        default: state <= ST_OFF;
      endcase
    end
  end

  ws_sat_timer #(.LIMIT(RST_TICKS)) u_rst_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (state == ST_OFF),
    .tick    (tick),
    .expired (rst_expired)
  );

  ws_conv_bank #(.NUM_CONV(NUM_CONV), .IDX_W(SW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .latch    (ev_enter),
    .keep_in  (keep_on),
    .live_off (state == ST_OFF),
    .step     (step),
    .step_idx (step_idx),
    .en       (conv_en),
    .load     (load_default)
  );

  ws_sticky_flag u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (ev_to_wdog),
    .clr   (irq_clear),
    .flag  (warm_irq)
  );

  assign sys_rst_n  = (state == ST_WDOG);
  assign proc_rst_n = 1'b1;
  assign clk_out_en = in_warm ? clk_hold : clk_cfg;

  // Guards next to the sequencing logic
  assert_enter_from_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_INIT && $past(state) != ST_INIT) |-> ($past(state) == ST_OFF && $past(turn_on)));
  assert_init_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_INIT && $past(state) == ST_INIT) |-> $stable(conv_en));
  assert_bad_supply_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_supply_bad |=> (state == ST_OFF));
  assert_slot_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= SW'(NUM_CONV - 1));
  assert_seq_done_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_seq_done |=> (state == ST_HOLD));
  assert_proc_rst_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    proc_rst_n);
  assert_clk_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_warm && $past(in_warm)) |-> $stable(clk_out_en));
  assert_release_after_timer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> ($past(rst_expired) && $past(state) == ST_HOLD));
  assert_irq_on_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> warm_irq);
endmodule

// File: tb/sim_warm_start_seq.sv
module sim_warm_start_seq;
  localparam int N = 5, INIT = 263, SLOT = 16, RST = 1024;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, tick = 1'b0, turn_on = 1'b0, supply_ok = 1'b1, clk_cfg = 1'b0, irq_clear = 1'b0;
  logic [N-1:0] keep_on = '0;
  logic [N-1:0] conv_en, load_default;
  logic sys_rst_n, proc_rst_n, clk_out_en, warm_irq;

  warm_start_seq #(.NUM_CONV(N), .INIT_TICKS(INIT), .SLOT_TICKS(SLOT), .RST_TICKS(RST)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .turn_on(turn_on), .keep_on(keep_on),
    .supply_ok(supply_ok), .clk_cfg(clk_cfg), .irq_clear(irq_clear),
    .conv_en(conv_en), .load_default(load_default), .sys_rst_n(sys_rst_n),
    .proc_rst_n(proc_rst_n), .clk_out_en(clk_out_en), .warm_irq(warm_irq));

  typedef struct {
    int           rel;
    logic [N-1:0] en;
    logic [N-1:0] ld;
    logic         srst;
    logic         irq;
  } exp_t;
  exp_t q[$];

  int cyc = 0, t0 = 0, div = 1, total = 0, bad = 0;
  bit mon_on = 1'b0;
  logic [2*N+1:0] last_obs;

  always @(posedge clk) cyc++;

  // tick source: every cycle, or every other cycle starting on the first edge after entry
  always @(negedge clk) begin
    if (div == 1) tick = 1'b1;
    else          tick = (((cyc - t0) % 2) == 0);
  end

  // scoreboard monitor: every change of the observed outputs pops one expected item
  always @(negedge clk) begin
    if (mon_on && ({conv_en, load_default, sys_rst_n, warm_irq} !== last_obs)) begin
      last_obs = {conv_en, load_default, sys_rst_n, warm_irq};
      total++;
      if (q.size() == 0) begin
        bad++;
        $display("FAIL R1 R2 R3: unexpected change rel=%0d en=%b ld=%b srst=%b irq=%b, expected no change",
                 cyc - t0, conv_en, load_default, sys_rst_n, warm_irq);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.rel != cyc - t0 || e.en !== conv_en || e.ld !== load_default ||
            e.srst !== sys_rst_n || e.irq !== warm_irq) begin
          bad++;
          $display("FAIL R4 R5 R6 R9 R10: rel=%0d en=%b ld=%b srst=%b irq=%b, expected rel=%0d en=%b ld=%b srst=%b irq=%b",
                   cyc - t0, conv_en, load_default, sys_rst_n, warm_irq,
                   e.rel, e.en, e.ld, e.srst, e.irq);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int rel_of(input int n, input int d);
    return (d == 1) ? n : 2 * n - 1;
  endfunction

  task automatic do_reset();
    mon_on = 1'b0;
    rst_n = 1'b0; turn_on = 1'b0; irq_clear = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic arm();
    t0 = cyc + 1;
    last_obs = {conv_en, load_default, sys_rst_n, warm_irq};
    mon_on = 1'b1;
  endtask

  task automatic wait_rel(input int r);
    while (cyc - t0 < r) @(negedge clk);
  endtask

  // driver: pushes the expected output changes, then fires the turn-on pulse
  task automatic run_warm(input logic [N-1:0] keep, input int d, input bit good);
    @(negedge clk);
    keep_on = keep; supply_ok = good; div = d;
    if (good) begin
      for (int k = 0; k < N; k++) begin
        int r;
        logic [N-1:0] en;
        r  = rel_of(INIT + k * SLOT, d);
        en = keep | N'((1 << (k + 1)) - 1);
        q.push_back('{r,     en, N'(1 << k), 1'b0, 1'b0});
        q.push_back('{r + 1, en, '0,         1'b0, 1'b0});
      end
      q.push_back('{rel_of(RST, d) + 1, {N{1'b1}}, '0, 1'b1, 1'b1});
    end
    arm();
    turn_on = 1'b1;
    @(negedge clk);
    turn_on = 1'b0;
  endtask

  initial begin
    // ---- scenario A: nothing kept, tick every cycle
    keep_on = '0; clk_cfg = 1'b1; supply_ok = 1'b1;
    do_reset();
    chk("R7 reset sys_rst_n", sys_rst_n, 0);
    chk("R7 reset proc_rst_n", proc_rst_n, 1);
    chk("R5 reset conv_en", conv_en, 0);
    chk("R6 reset load_default", load_default, 0);
    chk("R10 reset warm_irq", warm_irq, 0);
    chk("R8 off clk_out_en", clk_out_en, 1);

    run_warm('0, 1, 1'b1);
    wait_rel(50);
    clk_cfg = 1'b0;
    keep_on = {N{1'b1}};
    wait_rel(100);
    chk("R8 clk frozen in sequence", clk_out_en, 1);
    chk("R5 live keep_on ignored", conv_en, 0);
    chk("R7 sys reset held", sys_rst_n, 0);
    wait_rel(RST + 10);
    chk("R9 all events seen", q.size(), 0);
    chk("R9 sys reset released", sys_rst_n, 1);
    chk("R8 clk follows cfg in watchdog", clk_out_en, 0);
    chk("R7 proc reset high", proc_rst_n, 1);

    // turn-on in the watchdog state must change nothing
    @(negedge clk);
    arm();
    turn_on = 1'b1;
    @(negedge clk);
    turn_on = 1'b0;
    wait_rel(INIT + N * SLOT + 20);
    chk("R1 turn_on ignored, sys_rst_n", sys_rst_n, 1);
    chk("R1 turn_on ignored, conv_en", conv_en, {N{1'b1}});

    // interrupt clear
    @(negedge clk);
    arm();
    q.push_back('{0, {N{1'b1}}, '0, 1'b1, 1'b0});
    irq_clear = 1'b1;
    @(negedge clk);
    irq_clear = 1'b0;
    wait_rel(4);
    chk("R10 irq cleared", warm_irq, 0);
    chk("R10 clear event seen", q.size(), 0);

    // ---- scenario B: some converters kept, tick every other cycle
    keep_on = 5'b10110; clk_cfg = 1'b0;
    do_reset();
    chk("R5 off conv_en follows keep_on", conv_en, 5'b10110);
    run_warm(5'b10110, 2, 1'b1);
    wait_rel(rel_of(INIT, 2) - 2);
    chk("R2 init still quiet", conv_en, 5'b10110);
    chk("R2 no strobe in init", load_default, 0);
    wait_rel(rel_of(RST, 2) + 10);
    chk("R9 half-rate events seen", q.size(), 0);
    chk("R10 irq set", warm_irq, 1);

    // ---- scenario C: supply fails qualification, then a fresh start succeeds
    keep_on = 5'b01001;
    do_reset();
    run_warm(5'b01001, 1, 1'b0);
    wait_rel(INIT + 20);
    chk("R3 only kept converters on", conv_en, 5'b01001);
    chk("R3 no strobes", load_default, 0);
    chk("R3 sys reset still low", sys_rst_n, 0);
    chk("R3 no events", q.size(), 0);
    run_warm(5'b01001, 1, 1'b1);
    wait_rel(RST + 10);
    chk("R3 restart completes", q.size(), 0);
    chk("R3 restart reaches watchdog", sys_rst_n, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // watchdog on the run itself
  always @(posedge clk) begin
    if (cyc > 60000) begin
      total++;
      bad++;
      $display("FAIL R9: run did not finish, actual cycles=%0d expected below 60000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule